// File: doc/BRIEF.md
# Dual-Channel IDE Bank-Switch Decoder

This block sits between a host I/O bus and two IDE channels that are reached through a single shared window of I/O ports. A bank register chooses which channel the shared window talks to. Task-file, 16-bit data, device-control and alternate-status accesses are decoded from the host address and steered, as single-cycle strobes, to the channel that is selected. Each channel appears as a plain register port: a register index, write and read strobes, write data and returned read data.

Beyond steering, the block answers three of its own ports. The first is the bank register, which reads back the current selection. The second is a drive-presence query: a write loads a two-bit shift register with the master and slave presence of the selected channel, and each read returns one presence bit and then shifts. The third is a drive/head readback port, built from the selected channel's head-select field and its active unit. Host read data is combinational from the address and strobes in the same cycle. State changes (the bank selection and the presence shift register) take effect at the clock edge that ends the access.

Top module: `ide_bank_decoder`

## Requirements
- R1: A byte write to the bank register with data bit 7 clear selects channel 0 or 1 from data bit 0.
- R2: A byte write to the bank register with data bit 7 set leaves the channel selection unchanged.
- R3: A byte read of the bank register, at 0x430 or at its alias 0x432, returns 0x0000 when channel 0 is selected and 0x0001 when channel 1 is selected.
- R4: A byte access to a task-file port 0x640 + 2*i (i = 0..7) asserts exactly one strobe, on the selected channel only, with register index i and ch_ctl low. A byte read returns the channel's low data byte, zero-extended.
- R5: A 16-bit access (host_word high) at 0x640 is forwarded with index 0 and ch_word high. A read returns all 16 channel data bits.
- R6: A byte write to 0x74C strobes the selected channel with ch_ctl high (device control). A byte read of 0x74C strobes it with ch_ctl high and returns that channel's low data byte (alternate status).
- R7: A byte write to 0xF1 loads the presence shift register: bit 0 takes the selected channel's master present input and bit 1 takes its slave present input.
- R8: A byte read of 0xF0 returns 0x0001, with bit 5 also set (0x0021) when shift-register bit 0 is 0. It shifts the register right by one at the end of the read, and only on such a read, never on an idle cycle.
- R9: A byte read of 0x74E returns a value with bits 7:6 set and bits 5:2 equal to the inverted head-select nibble of the selected channel. Bits 1:0 are 01 if that channel's active unit is 1 and 10 otherwise.
- R10: Reset selects channel 0 and clears the presence shift register.
- R11: An access to any other address or kind (odd addresses, 16-bit accesses away from 0x640, a write to 0xF0 or 0x74E, a read of 0xF1) asserts no channel strobe and changes no state. A byte read of this kind returns 0x00FF and a 16-bit read returns 0xFFFF.
- R12: A change of bank selection applies from the access after the bank write. The bank write itself strobes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 12 | Host I/O address |
| host_wr | input | 1 | Host write strobe (wins over host_rd) |
| host_rd | input | 1 | Host read strobe |
| host_word | input | 1 | High for a 16-bit access, low for a byte access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the strobe cycle |
| ch_wr | output | 2 | Per-channel write strobe |
| ch_rd | output | 2 | Per-channel read strobe |
| ch_reg | output | 3 | Register index shared by both channels |
| ch_ctl | output | 1 | Access targets device control / alternate status |
| ch_word | output | 1 | Access is 16-bit |
| ch_wdata | output | 16 | Write data shared by both channels |
| ch_rdata | input | 32 | Channel read data, channel 1 in bits 31:16 |
| ch_head | input | 8 | Head-select nibble per channel, channel 1 in bits 7:4 |
| ch_unit | input | 2 | Active unit per channel (1 = unit 1) |
| dev_present | input | 4 | Presence per channel: {ch1 slave, ch1 master, ch0 slave, ch0 master} |

## Verification
The steering function is exercised with byte task-file reads and writes at several indexes, a 16-bit data read, and control writes and status reads, under each bank selection. The channel models return channel-tagged data, so a mis-steered strobe, a wrong index or a wrong byte lane each shows as a distinct wrong value. The presence port is read through full load-and-drain sequences, with idle cycles and unmapped accesses placed between reads, which separates a shift on every cycle or on a stray access from a shift on real reads. Bank writes with bit 7 set, with bit 7 clear, and at a near-miss address separate a stale selection from one that was wrongly ignored, and a reset after loading the register for channel 1 shows that both pieces of state are cleared.

// File: rtl/ide_bank_pkg.sv
package ide_bank_pkg;

  // Host port map; the decoder compares these zero-extended to ADDR_W.
  localparam int unsigned PRES_RD_ADDR = 32'h0F0;
  localparam int unsigned PRES_LD_ADDR = 32'h0F1;
  localparam int unsigned BANK_ADDR_A  = 32'h430;
  localparam int unsigned BANK_ADDR_B  = 32'h432;
  localparam int unsigned TF_BASE_ADDR = 32'h640;
  localparam int unsigned CTL_ADDR     = 32'h74C;
  localparam int unsigned SDH_ADDR     = 32'h74E;

  // Kinds of access the decoder resolves one host cycle into.
  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_BANK    = 3'd1,
    ACC_PRES_RD = 3'd2,
    ACC_PRES_LD = 3'd3,
    ACC_TASK    = 3'd4,
    ACC_DATAW   = 3'd5,
    ACC_CTL     = 3'd6,
    ACC_SDH     = 3'd7
  } acc_kind_e;

  // Byte values placed on the presence and drive/head read ports.
  localparam logic [7:0] PRES_BASE_VAL   = 8'h01;
  localparam logic [7:0] PRES_ABSENT_BIT = 8'h20;
  localparam logic [7:0] SDH_FIXED_BITS  = 8'hC0;
  localparam logic [1:0] SDH_UNIT1_CODE  = 2'b01;
  localparam logic [1:0] SDH_UNIT0_CODE  = 2'b10;

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NREG   = 8,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              word,
  output acc_kind_e         kind,
  output logic              is_wr,
  output logic              is_rd,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] A_PRES_RD = ADDR_W'(PRES_RD_ADDR);
  localparam logic [ADDR_W-1:0] A_PRES_LD = ADDR_W'(PRES_LD_ADDR);
  localparam logic [ADDR_W-1:0] A_BANK_A  = ADDR_W'(BANK_ADDR_A);
  localparam logic [ADDR_W-1:0] A_BANK_B  = ADDR_W'(BANK_ADDR_B);
  localparam logic [ADDR_W-1:0] A_TF_BASE = ADDR_W'(TF_BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_TF_END  = ADDR_W'(TF_BASE_ADDR + 2 * NREG);
  localparam logic [ADDR_W-1:0] A_CTL     = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_SDH     = ADDR_W'(SDH_ADDR);

  logic              any_acc;
  logic              in_tf;
  logic [ADDR_W-1:0] tf_off;

  // A write takes priority over a simultaneous read.
  assign is_wr   = wr;
  assign is_rd   = rd & ~wr;
  assign any_acc = is_wr | is_rd;

  assign tf_off = addr - A_TF_BASE;
  assign in_tf  = (addr >= A_TF_BASE) && (addr < A_TF_END) && !addr[0];

  always_comb begin
    kind = ACC_NONE;
    idx  = '0;
    if (any_acc) begin
      if (word) begin
        if (addr == A_TF_BASE) begin
          kind = ACC_DATAW;
        end
      end else if ((addr == A_BANK_A) || (addr == A_BANK_B)) begin
        kind = ACC_BANK;
      end else if ((addr == A_PRES_RD) && is_rd) begin
        kind = ACC_PRES_RD;
      end else if ((addr == A_PRES_LD) && is_wr) begin
        kind = ACC_PRES_LD;
      end else if (in_tf) begin
        kind = ACC_TASK;
        idx  = tf_off[IDX_W:1];
      end else if (addr == A_CTL) begin
        kind = ACC_CTL;
      end else if ((addr == A_SDH) && is_rd) begin
        kind = ACC_SDH;
      end
    end
  end

endmodule

// File: rtl/ide_bank_reg.sv
module ide_bank_reg #(
  parameter int unsigned NCH    = 2,
  localparam int unsigned SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [SEL_W-1:0] sel
);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             sel_en;
  logic             lock_bit;
  logic             in_range;

  assign lock_bit = wdata[7];
  assign in_range = (32'(wdata[SEL_W-1:0]) < NCH);
  assign sel_en   = wr_en & ~lock_bit & in_range;

  always_comb begin
    sel_d = sel_q;
    if (sel_en) begin
      sel_d = wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel = sel_q;

endmodule

// File: rtl/ide_presence_shift.sv
module ide_presence_shift #(
  parameter int unsigned NDEV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NDEV-1:0] load_val,
  input  logic            shift,
  output logic            head_bit,
  output logic [NDEV-1:0] q
);

  logic [NDEV-1:0] sh_q;
  logic [NDEV-1:0] sh_d;
  logic            sh_en;

  assign sh_en = load | shift;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_val;
    end else if (shift) begin
      sh_d = sh_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign head_bit = sh_q[0];
  assign q        = sh_q;

endmodule

// File: rtl/ide_bank_decoder.sv
module ide_bank_decoder
  import ide_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NCH    = 2,
  parameter int unsigned NREG   = 8,
  parameter int unsigned HEAD_W = 4,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic                  host_word,
  input  logic [DATA_W-1:0]     host_wdata,
  output logic [DATA_W-1:0]     host_rdata,
  output logic [NCH-1:0]        ch_wr,
  output logic [NCH-1:0]        ch_rd,
  output logic [IDX_W-1:0]      ch_reg,
  output logic                  ch_ctl,
  output logic                  ch_word,
  output logic [DATA_W-1:0]     ch_wdata,
  input  logic [NCH*DATA_W-1:0] ch_rdata,
  input  logic [NCH*HEAD_W-1:0] ch_head,
  input  logic [NCH-1:0]        ch_unit,
  input  logic [NCH*2-1:0]      dev_present
);

  localparam logic [DATA_W-1:0] BYTE_MISS = DATA_W'(8'hFF);
  localparam logic [DATA_W-1:0] WORD_MISS = '1;

  acc_kind_e        kind;
  logic             is_wr;
  logic             is_rd;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] bank_q;
  logic             pres_lsb;
  logic [1:0]       pres_q;

  logic             fwd_acc;
  logic [DATA_W-1:0] sel_rdata;
  logic [HEAD_W-1:0] sel_head;
  logic             sel_unit;
  logic [1:0]       sel_present;
  logic [7:0]       pres_byte;
  logic [7:0]       sdh_byte;

  ide_addr_decode #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG)
  ) dec_i (
    .addr  (host_addr),
    .wr    (host_wr),
    .rd    (host_rd),
    .word  (host_word),
    .kind  (kind),
    .is_wr (is_wr),
    .is_rd (is_rd),
    .idx   (idx)
  );

  ide_bank_reg #(
    .NCH (NCH)
  ) bank_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (is_wr && (kind == ACC_BANK)),
    .wdata (host_wdata[7:0]),
    .sel   (bank_q)
  );

  // Presence bits of the selected channel: {slave, master}.
  assign sel_present = dev_present[bank_q*2 +: 2];

  ide_presence_shift #(
    .NDEV (2)
  ) pres_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (kind == ACC_PRES_LD),
    .load_val (sel_present),
    .shift    (kind == ACC_PRES_RD),
    .head_bit (pres_lsb),
    .q        (pres_q)
  );

  // Forwarded kinds reach the channel selected before this access.
  assign fwd_acc = (kind == ACC_TASK) || (kind == ACC_DATAW) || (kind == ACC_CTL);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch_strobe
      logic hit;
      assign hit      = fwd_acc && (32'(bank_q) == c);
      assign ch_wr[c] = hit & is_wr;
      assign ch_rd[c] = hit & is_rd;
    end
  endgenerate

  assign ch_reg   = (kind == ACC_TASK) ? idx : '0;
  assign ch_ctl   = (kind == ACC_CTL);
  assign ch_word  = (kind == ACC_DATAW);
  assign ch_wdata = host_wdata;

  assign sel_rdata = ch_rdata[bank_q*DATA_W +: DATA_W];
  assign sel_head  = ch_head[bank_q*HEAD_W +: HEAD_W];
  assign sel_unit  = ch_unit[bank_q];

  assign pres_byte = PRES_BASE_VAL | (pres_lsb ? 8'h00 : PRES_ABSENT_BIT);
  assign sdh_byte  = SDH_FIXED_BITS
                   | {2'b00, 4'(~sel_head), 2'b00}
                   | {6'b0, (sel_unit ? SDH_UNIT1_CODE : SDH_UNIT0_CODE)};

  always_comb begin
    host_rdata = host_word ? WORD_MISS : BYTE_MISS;
    if (is_rd) begin
      unique case (kind)
        ACC_BANK:    host_rdata = DATA_W'(bank_q);
        ACC_PRES_RD: host_rdata = DATA_W'(pres_byte);
        ACC_TASK:    host_rdata = DATA_W'(sel_rdata[7:0]);
        ACC_CTL:     host_rdata = DATA_W'(sel_rdata[7:0]);
        ACC_DATAW:   host_rdata = sel_rdata;
        ACC_SDH:     host_rdata = DATA_W'(sdh_byte);
        default:     host_rdata = host_word ? WORD_MISS : BYTE_MISS;
      endcase
    end
  end

endmodule

// File: rtl/ide_bank_decoder_chk.sv
module ide_bank_decoder_chk
  import ide_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NCH    = 2,
  parameter int unsigned SEL_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic              host_word,
  input logic [DATA_W-1:0] host_wdata,
  input logic [NCH-1:0]    ch_wr,
  input logic [NCH-1:0]    ch_rd,
  input logic [SEL_W-1:0]  bank_q,
  input logic [1:0]        pres_q
);

  logic bank_hit;
  logic pres_read;
  logic fwd_addr;

  assign bank_hit  = host_wr && !host_word &&
                     ((host_addr == ADDR_W'(BANK_ADDR_A)) || (host_addr == ADDR_W'(BANK_ADDR_B)));
  assign pres_read = host_rd && !host_wr && !host_word && (host_addr == ADDR_W'(PRES_RD_ADDR));
  assign fwd_addr  = (host_addr >= ADDR_W'(TF_BASE_ADDR)) &&
                     (host_addr < ADDR_W'(TF_BASE_ADDR + 16)) || (host_addr == ADDR_W'(CTL_ADDR));

  // R1: unlocked bank write selects from data bit 0
  a_r1_bank_select: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_hit && !host_wdata[7]) |=> (32'(bank_q) == 32'($past(host_wdata[0]))));

  // R2: locked bank write keeps the selection
  a_r2_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_hit && host_wdata[7]) |=> $stable(bank_q));

  // R4: at most one strobe at a time
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_wr, ch_rd}));

  // R4: a strobe only ever reaches the selected channel
  a_r4_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_wr | ch_rd) != '0) |-> (((ch_wr | ch_rd) >> bank_q) == NCH'(1)));

  // R8: a presence read shifts by one
  a_r8_shift_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    pres_read |=> (pres_q == ($past(pres_q) >> 1)));

  // R8: idle cycles leave the presence register alone
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd && !host_wr) |=> $stable(pres_q));

  // R11: strobes appear only for forwarded addresses
  a_r11_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_wr | ch_rd) != '0) |-> fwd_addr);

  // R12: a bank write strobes no channel
  a_r12_bank_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit |-> ((ch_wr | ch_rd) == '0));

  // R10: state held cleared while reset is asserted
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_state: assert ((bank_q == '0) && (pres_q == 2'b00));
    end
  end

endmodule

bind ide_bank_decoder ide_bank_decoder_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NCH    (NCH),
  .SEL_W  (SEL_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_word  (host_word),
  .host_wdata (host_wdata),
  .ch_wr      (ch_wr),
  .ch_rd      (ch_rd),
  .bank_q     (bank_q),
  .pres_q     (pres_q)
);

// File: tb/ide_bank_decoder_tb_top.sv
module ide_bank_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic [11:0] host_addr;
  logic        host_wr;
  logic        host_rd;
  logic        host_word;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [1:0]  ch_wr;
  logic [1:0]  ch_rd;
  logic [2:0]  ch_reg;
  logic        ch_ctl;
  logic        ch_word;
  logic [15:0] ch_wdata;
  logic [31:0] ch_rdata;
  logic [7:0]  ch_head;
  logic [1:0]  ch_unit;
  logic [3:0]  dev_present;

  int tests;
  int fails;
  bit done;

  // Channel models: data tagged by channel, control flag and index.
  assign ch_rdata    = {8'hB0, 4'h2, ch_ctl, ch_reg, 8'hA0, 4'h1, ch_ctl, ch_reg};
  assign ch_head     = {4'hA, 4'h3};
  assign ch_unit     = 2'b10;
  assign dev_present = 4'b0110;

  ide_bank_decoder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_word   (host_word),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .ch_wr       (ch_wr),
    .ch_rd       (ch_rd),
    .ch_reg      (ch_reg),
    .ch_ctl      (ch_ctl),
    .ch_word     (ch_word),
    .ch_wdata    (ch_wdata),
    .ch_rdata    (ch_rdata),
    .ch_head     (ch_head),
    .ch_unit     (ch_unit),
    .dev_present (dev_present)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        word;
    logic [11:0] addr;
    logic [15:0] wdata;
    logic        chk_data;
    logic [15:0] exp_data;
    logic [1:0]  exp_wr;
    logic [1:0]  exp_rd;
    logic [2:0]  exp_reg;
    logic        exp_ctl;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b1,1'b0,12'h430,16'h0000,1'b1,16'h0000,2'b00,2'b00,3'd0,1'b0,4'd3},  // R3 ch0 selected
    '{1'b0,1'b1,1'b0,12'h64A,16'h0000,1'b1,16'h0015,2'b00,2'b01,3'd5,1'b0,4'd4},  // R4 read idx 5
    '{1'b1,1'b0,1'b0,12'h644,16'h0055,1'b0,16'h0000,2'b01,2'b00,3'd2,1'b0,4'd4},  // R4 write idx 2
    '{1'b1,1'b0,1'b0,12'h430,16'h0081,1'b0,16'h0000,2'b00,2'b00,3'd0,1'b0,4'd2},  // R2 locked write
    '{1'b0,1'b1,1'b0,12'h432,16'h0000,1'b1,16'h0000,2'b00,2'b00,3'd0,1'b0,4'd2},  // R2 still ch0
    '{1'b1,1'b0,1'b0,12'h432,16'h0001,1'b0,16'h0000,2'b00,2'b00,3'd0,1'b0,4'd12}, // R12 no strobe
    '{1'b0,1'b1,1'b0,12'h430,16'h0000,1'b1,16'h0001,2'b00,2'b00,3'd0,1'b0,4'd1},  // R1 ch1 now
    '{1'b0,1'b1,1'b0,12'h64E,16'h0000,1'b1,16'h0027,2'b00,2'b10,3'd7,1'b0,4'd4},  // R4 ch1 idx 7
    '{1'b0,1'b1,1'b1,12'h640,16'h0000,1'b1,16'hB020,2'b00,2'b10,3'd0,1'b0,4'd5},  // R5 word read
    '{1'b0,1'b1,1'b0,12'h74C,16'h0000,1'b1,16'h0028,2'b00,2'b10,3'd0,1'b1,4'd6},  // R6 alt status
    '{1'b1,1'b0,1'b0,12'h74C,16'h0004,1'b0,16'h0000,2'b10,2'b00,3'd0,1'b1,4'd6},  // R6 dev control
    '{1'b0,1'b1,1'b0,12'h74E,16'h0000,1'b1,16'h00D5,2'b00,2'b00,3'd0,1'b0,4'd9},  // R9 ch1 unit1
    '{1'b1,1'b0,1'b0,12'h430,16'h0000,1'b0,16'h0000,2'b00,2'b00,3'd0,1'b0,4'd1},  // R1 back to ch0
    '{1'b0,1'b1,1'b0,12'h74E,16'h0000,1'b1,16'h00F2,2'b00,2'b00,3'd0,1'b0,4'd9},  // R9 ch0 unit0
    '{1'b0,1'b1,1'b0,12'h123,16'h0000,1'b1,16'h00FF,2'b00,2'b00,3'd0,1'b0,4'd11}, // R11 byte miss
    '{1'b0,1'b1,1'b1,12'h642,16'h0000,1'b1,16'hFFFF,2'b00,2'b00,3'd0,1'b0,4'd11}, // R11 word miss
    '{1'b0,1'b1,1'b0,12'h641,16'h0000,1'b1,16'h00FF,2'b00,2'b00,3'd0,1'b0,4'd11}, // R11 odd read
    '{1'b1,1'b0,1'b0,12'h645,16'h00AA,1'b0,16'h0000,2'b00,2'b00,3'd0,1'b0,4'd11}  // R11 odd write
  };

  logic [15:0] cap_data;
  logic [1:0]  cap_wr;
  logic [1:0]  cap_rd;
  logic [2:0]  cap_reg;
  logic        cap_ctl;

  task automatic do_acc(input logic wr, input logic rd, input logic word,
                        input logic [11:0] addr, input logic [15:0] wdata);
    @(negedge clk);
    host_wr    = wr;
    host_rd    = rd;
    host_word  = word;
    host_addr  = addr;
    host_wdata = wdata;
    #2;
    cap_data = host_rdata;
    cap_wr   = ch_wr;
    cap_rd   = ch_rd;
    cap_reg  = ch_reg;
    cap_ctl  = ch_ctl;
    @(posedge clk);
    #1;
    host_wr   = 1'b0;
    host_rd   = 1'b0;
    host_word = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [11:0] addr, input logic [15:0] exp);
    do_acc(1'b0, 1'b1, 1'b0, addr, 16'h0000);
    check(req, {16'h0, cap_data}, {16'h0, exp});
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 0;
    host_wr = 0; host_rd = 0; host_word = 0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state: channel 0, presence cleared
    rd_check("R10 bank after reset", 12'h430, 16'h0000);
    rd_check("R10 presence after reset", 12'h0F0, 16'h0021);

    for (int i = 0; i < NVEC; i++) begin
      do_acc(VEC[i].wr, VEC[i].rd, VEC[i].word, VEC[i].addr, VEC[i].wdata);
      tests++;
      if ((VEC[i].chk_data && (cap_data !== VEC[i].exp_data)) ||
          (cap_wr !== VEC[i].exp_wr) || (cap_rd !== VEC[i].exp_rd) ||
          (((cap_wr | cap_rd) != 2'b00) &&
           ((cap_reg !== VEC[i].exp_reg) || (cap_ctl !== VEC[i].exp_ctl)))) begin
        fails++;
        $display("FAIL R%0d vec %0d: actual %h/%b/%b/%0d/%b expected %h/%b/%b/%0d/%b",
                 VEC[i].req, i, cap_data, cap_wr, cap_rd, cap_reg, cap_ctl,
                 VEC[i].exp_data, VEC[i].exp_wr, VEC[i].exp_rd, VEC[i].exp_reg, VEC[i].exp_ctl);
      end
    end

    // R7 / R8: load ch0 presence {slave=1, master=0} and drain it
    do_acc(1'b1, 1'b0, 1'b0, 12'h0F1, 16'h0000);
    rd_check("R7 ch0 master absent", 12'h0F0, 16'h0021);
    rd_check("R8 ch0 slave present", 12'h0F0, 16'h0001);
    rd_check("R8 drained", 12'h0F0, 16'h0021);

    // R8: idle cycles do not shift
    do_acc(1'b1, 1'b0, 1'b0, 12'h0F1, 16'h0000);
    repeat (3) @(posedge clk);
    rd_check("R8 idle no shift first", 12'h0F0, 16'h0021);
    rd_check("R8 idle no shift second", 12'h0F0, 16'h0001);

    // R11: unmapped accesses near the presence ports do not shift
    do_acc(1'b1, 1'b0, 1'b0, 12'h0F1, 16'h0000);
    do_acc(1'b1, 1'b0, 1'b0, 12'h0F0, 16'h0000);
    rd_check("R11 read of load port", 12'h0F1, 16'h00FF);
    rd_check("R11 presence unshifted", 12'h0F0, 16'h0021);
    rd_check("R11 presence next bit", 12'h0F0, 16'h0001);

    // R11: near-miss bank address leaves selection alone
    do_acc(1'b1, 1'b0, 1'b0, 12'h431, 16'h0001);
    rd_check("R11 bank unchanged", 12'h430, 16'h0000);

    // R12: bank write then immediate access uses the new channel
    do_acc(1'b1, 1'b0, 1'b0, 12'h430, 16'h0001);
    check("R12 bank write strobes", {30'h0, cap_wr | cap_rd}, 32'h0);
    do_acc(1'b0, 1'b1, 1'b0, 12'h640, 16'h0000);
    check("R12 next access ch1", {14'h0, cap_rd, cap_data}, {14'h0, 2'b10, 16'h0020});

    // R7: ch1 presence {slave=0, master=1}
    do_acc(1'b1, 1'b0, 1'b0, 12'h0F1, 16'h0000);
    rd_check("R7 ch1 master present", 12'h0F0, 16'h0001);
    do_acc(1'b1, 1'b0, 1'b0, 12'h0F1, 16'h0000);

    // R10: reset mid-run clears bank and presence
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd_check("R10 bank cleared", 12'h430, 16'h0000);
    rd_check("R10 presence cleared", 12'h0F0, 16'h0021);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule